// File: doc/BRIEF.md
# Trimmable Nanosecond Time Counter

This block keeps a 64-bit time value in nanoseconds. On each enabled reference clock cycle it adds a programmable per-tick step. Its rate can be trimmed in two ways. The first is a one-shot burst: a fixed number of ticks use an alternative compensation step. The second is periodic: a down-counter swaps in the compensation step once every programmable number of ticks. Averaged over time, this gives a fractional rate adjustment.

Software reaches the block through a simple word-wide register port. Through it, software can:
- enable counting and set both step values;
- load the burst and period counts;
- set either half of the time value;
- read a sticky overflow flag.

Reading the low time word captures the high word, so a two-read access is coherent. A neighbouring compare unit can request a wrap, which returns the time value to zero on the next tick. The current time is also driven continuously to other logic.

Top module: `tc_time_counter`

## Requirements
- R1: After reset the counter is 0, counting is disabled, the default and compensation steps both equal parameter DEF_RST (5), the burst count, period, overflow flag and latched high word are 0.
- R2: Control word at address 0: bit 0 enables counting. While bit 0 is 0, the time value, the burst count and the period counter do not change, and a wrap request has no effect.
- R3: Control bits 7:4 hold the default step. Each enabled cycle with no compensation adds that step to the time value, which appears on time_o one cycle later.
- R4: Control bits 19:8 hold the compensation step. Address 2 holds a 24-bit burst count. While the burst count is nonzero, each enabled cycle adds the compensation step and decrements the count. Reading address 2 returns the remaining count.
- R5: Address 3 holds a period P. When P is nonzero, every P-th enabled cycle after it is written adds the compensation step instead of the default step. When P is 0, periodic compensation is off.
- R6: When a burst tick and a period tick coincide, the compensation step is added once. The period counter keeps running during a burst.
- R7: A read of address 4 (low time word) captures the high 32 bits of the time value at that moment. A read of address 5 returns the captured word, not the live one.
- R8: A write to address 4 or 5 replaces that half of the time value and leaves the other half unchanged. No step is added in that cycle.
- R9: wrap_i on an enabled cycle loads 0 in place of adding a step. A time-word write in the same cycle takes priority over the wrap.
- R10: Address 1 bit 0 is a sticky flag, set when adding a step carries out of bit 63, and cleared by writing 1. If a carry and a clear fall in the same cycle, the flag stays set.
- R11: Addresses 6 and 7 read as 0, and writes to them change nothing. Read data is combinational from the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (drives the high-word capture) |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| wrap_i | input | 1 | Wrap request from a compare unit |
| time_o | output | 64 | Current time value |

## Verification
Several collisions can happen in a single cycle: a carry out of bit 63 with a write-one-to-clear of the flag, a wrap request with a time-word write, and a burst tick with a period tick. The bench builds each of these on purpose. For the overflow case, it loads the time just below the top, so the carry lands in the cycle that also carries the clear, and then reads the flag back. In random traffic, wraps, writes and reads with narrow counts collide at random, and every read and every cycle of time_o is compared against a reference model driven from the requirements.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int ADDR_W   = 3;
  localparam int EN_BIT   = 0;
  localparam int DEF_LSB  = 4;
  localparam int COMP_LSB = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 3'd0,
    REG_STAT = 3'd1,
    REG_FAST = 3'd2,
    REG_SLOW = 3'd3,
    REG_TLO  = 3'd4,
    REG_THI  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/tc_rate_sel.sv
module tc_rate_sel #(
  parameter int DEF_W  = 4,
  parameter int COMP_W = 12,
  parameter int FAST_W = 24,
  parameter int SLOW_W = 32,
  parameter int INC_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              fast_ld_i,
  input  logic [FAST_W-1:0] fast_val_i,
  input  logic              slow_ld_i,
  input  logic [SLOW_W-1:0] slow_val_i,
  input  logic [DEF_W-1:0]  def_inc_i,
  input  logic [COMP_W-1:0] comp_inc_i,
  output logic [INC_W-1:0]  inc_o,
  output logic              comp_sel_o,
  output logic [FAST_W-1:0] fast_cnt_o,
  output logic [SLOW_W-1:0] slow_per_o
);
  logic [FAST_W-1:0] fast_q;
  logic [SLOW_W-1:0] per_q, rem_q;
  logic fast_act, slow_on, slow_hit;

  assign fast_act   = fast_q != '0;
  assign slow_on    = per_q != '0;
  assign slow_hit   = slow_on && (rem_q <= SLOW_W'(1));
  assign comp_sel_o = fast_act || slow_hit;
  assign inc_o      = comp_sel_o ? INC_W'(comp_inc_i) : INC_W'(def_inc_i);
  assign fast_cnt_o = fast_q;
  assign slow_per_o = per_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fast_q <= '0;
    end else if (fast_ld_i) begin
      fast_q <= fast_val_i;
    end else if (tick_i && fast_act) begin
      fast_q <= fast_q - FAST_W'(1);
    end
  end

  // period keeps running during a burst
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q <= '0;
      rem_q <= '0;
    end else if (slow_ld_i) begin
      per_q <= slow_val_i;
      rem_q <= slow_val_i;
    end else if (tick_i && slow_on) begin
      rem_q <= slow_hit ? per_q : rem_q - SLOW_W'(1);
    end
  end
endmodule

// File: rtl/tc_accum.sv
module tc_accum #(
  parameter int CNT_W = 64,
  parameter int INC_W = 12,
  localparam int HALF = CNT_W / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wrap_i,
  input  logic [INC_W-1:0] inc_i,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [HALF-1:0]  wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             carry_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   sum;
  logic             sw_wr;

  assign sum     = {1'b0, cnt_q} + (CNT_W+1)'(inc_i);
  assign sw_wr   = wr_lo_i || wr_hi_i;
  assign carry_o = tick_i && !wrap_i && !sw_wr && sum[CNT_W];
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (wr_lo_i) begin
      cnt_q <= {cnt_q[CNT_W-1:HALF], wdata_i};
    end else if (wr_hi_i) begin
      cnt_q <= {wdata_i, cnt_q[HALF-1:0]};
    end else if (tick_i) begin
      cnt_q <= wrap_i ? '0 : sum[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/tc_time_counter.sv
module tc_time_counter
  import tc_pkg::*;
#(
  parameter int CNT_W   = 64,
  parameter int DATA_W  = 32,
  parameter int DEF_W   = 4,
  parameter int COMP_W  = 12,
  parameter int FAST_W  = 24,
  parameter int SLOW_W  = 32,
  parameter int DEF_RST = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              wrap_i,
  output logic [CNT_W-1:0]  time_o
);
  localparam int HALF  = CNT_W / 2;
  localparam int INC_W = (DEF_W > COMP_W) ? DEF_W : COMP_W;

  logic              en_q, ovf_q;
  logic [DEF_W-1:0]  def_q;
  logic [COMP_W-1:0] comp_q;
  logic [HALF-1:0]   hi_q;
  logic [INC_W-1:0]  inc;
  logic              comp_sel, carry;
  logic [FAST_W-1:0] fast_cnt;
  logic [SLOW_W-1:0] slow_per;
  logic [CNT_W-1:0]  cnt;
  logic wr_ctrl, wr_fast, wr_slow, wr_lo, wr_hi, time_wr, ovf_clr, rd_lo;

  assign wr_ctrl = reg_we_i && (reg_addr_i == REG_CTRL);
  assign wr_fast = reg_we_i && (reg_addr_i == REG_FAST);
  assign wr_slow = reg_we_i && (reg_addr_i == REG_SLOW);
  assign wr_lo   = reg_we_i && (reg_addr_i == REG_TLO);
  assign wr_hi   = reg_we_i && (reg_addr_i == REG_THI);
  assign ovf_clr = reg_we_i && (reg_addr_i == REG_STAT) && reg_wdata_i[0];
  assign rd_lo   = reg_re_i && (reg_addr_i == REG_TLO);
  assign time_wr = wr_lo || wr_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      def_q  <= DEF_W'(DEF_RST);
      comp_q <= COMP_W'(DEF_RST);
    end else if (wr_ctrl) begin
      en_q   <= reg_wdata_i[EN_BIT];
      def_q  <= reg_wdata_i[DEF_LSB +: DEF_W];
      comp_q <= reg_wdata_i[COMP_LSB +: COMP_W];
    end
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ovf_q <= 1'b0;
    else if (carry)   ovf_q <= 1'b1;
    else if (ovf_clr) ovf_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hi_q <= '0;
    else if (rd_lo) hi_q <= cnt[CNT_W-1:HALF];
  end

  tc_rate_sel #(
    .DEF_W(DEF_W), .COMP_W(COMP_W), .FAST_W(FAST_W),
    .SLOW_W(SLOW_W), .INC_W(INC_W)
  ) u_rate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (en_q),
    .fast_ld_i  (wr_fast),
    .fast_val_i (reg_wdata_i[FAST_W-1:0]),
    .slow_ld_i  (wr_slow),
    .slow_val_i (reg_wdata_i[SLOW_W-1:0]),
    .def_inc_i  (def_q),
    .comp_inc_i (comp_q),
    .inc_o      (inc),
    .comp_sel_o (comp_sel),
    .fast_cnt_o (fast_cnt),
    .slow_per_o (slow_per)
  );

  tc_accum #(.CNT_W(CNT_W), .INC_W(INC_W)) u_accum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (en_q),
    .wrap_i  (wrap_i),
    .inc_i   (inc),
    .wr_lo_i (wr_lo),
    .wr_hi_i (wr_hi),
    .wdata_i (reg_wdata_i[HALF-1:0]),
    .cnt_o   (cnt),
    .carry_o (carry)
  );

  assign time_o = cnt;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      REG_CTRL: begin
        reg_rdata_o[EN_BIT]                 = en_q;
        reg_rdata_o[DEF_LSB +: DEF_W]   = def_q;
        reg_rdata_o[COMP_LSB +: COMP_W] = comp_q;
      end
      REG_STAT: reg_rdata_o[0] = ovf_q;
      REG_FAST: reg_rdata_o[FAST_W-1:0] = fast_cnt;
      REG_SLOW: reg_rdata_o[SLOW_W-1:0] = slow_per;
      REG_TLO:  reg_rdata_o = cnt[HALF-1:0];
      REG_THI:  reg_rdata_o = hi_q;
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tc_time_counter_chk.sv
module tc_time_counter_chk #(
  parameter int CNT_W  = 64,
  parameter int FAST_W = 24,
  localparam int HALF  = CNT_W / 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en,
  input logic              wrap,
  input logic              time_wr,
  input logic [CNT_W-1:0]  cnt,
  input logic [FAST_W-1:0] fast,
  input logic              fast_ld,
  input logic              ovf,
  input logic              ovf_clr,
  input logic              rd_lo,
  input logic [HALF-1:0]   hi
);
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !time_wr) |=> (cnt == $past(cnt))); // R2

  AST_STEP_FORWARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !wrap && !time_wr && !(&cnt[CNT_W-1:HALF])) |=> (cnt >= $past(cnt))); // R3

  AST_BURST_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && (fast != '0) && !fast_ld) |=> (fast == $past(fast) - FAST_W'(1))); // R4

  AST_HI_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo |=> (hi == $past(cnt[CNT_W-1:HALF]))); // R7

  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && wrap && !time_wr) |=> (cnt == '0)); // R9

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf && !ovf_clr) |=> ovf); // R10
endmodule

bind tc_time_counter tc_time_counter_chk #(.CNT_W(CNT_W), .FAST_W(FAST_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en      (en_q),
  .wrap    (wrap_i),
  .time_wr (time_wr),
  .cnt     (cnt),
  .fast    (fast_cnt),
  .fast_ld (wr_fast),
  .ovf     (ovf_q),
  .ovf_clr (ovf_clr),
  .rd_lo   (rd_lo),
  .hi      (hi_q)
);

// File: tb/tc_time_counter_bench.sv
`timescale 1ns/1ps
module tc_time_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0, wrap = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] tval;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  logic [63:0] m_cnt;
  logic        m_en, m_ovf;
  logic [3:0]  m_def;
  logic [11:0] m_comp;
  logic [23:0] m_fast;
  logic [31:0] m_per, m_rem, m_hi;

  always #2.5 clk = ~clk;

  tc_time_counter u_tc_time_counter (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .wrap_i(wrap), .time_o(tval)
  );

  function automatic logic [31:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: model_read = {12'd0, m_comp, m_def, 3'd0, m_en};
      3'd1: model_read = {31'd0, m_ovf};
      3'd2: model_read = {8'd0, m_fast};
      3'd3: model_read = m_per;
      3'd4: model_read = m_cnt[31:0];
      3'd5: model_read = m_hi;
      default: model_read = 32'd0;
    endcase
  endfunction

  task automatic model_reset();
    m_cnt = '0; m_en = 0; m_ovf = 0; m_def = 4'd5; m_comp = 12'd5;
    m_fast = '0; m_per = '0; m_rem = '0; m_hi = '0;
  endtask

  task automatic model_step(input logic w, input logic r, input logic [2:0] a,
                            input logic [31:0] d, input logic wr);
    logic [63:0] n_cnt; logic n_ovf, hit, fact, carry;
    logic [23:0] n_fast; logic [31:0] n_rem, n_per, n_hi;
    logic [11:0] inc; logic [64:0] s;
    n_cnt = m_cnt; n_ovf = m_ovf; n_fast = m_fast; n_rem = m_rem;
    n_per = m_per; n_hi = m_hi; carry = 0;
    if (r && a == 3'd4) n_hi = m_cnt[63:32];
    if (m_en) begin
      fact = m_fast != 0;
      hit  = (m_per != 0) && (m_rem <= 1);
      inc  = (fact || hit) ? m_comp : {8'd0, m_def};
      s    = {1'b0, m_cnt} + {53'd0, inc};
      n_cnt = wr ? 64'd0 : s[63:0];
      carry = !wr && s[64];
      if (fact) n_fast = m_fast - 1;
      if (m_per != 0) n_rem = hit ? m_per : m_rem - 1;
    end
    if (w) begin
      case (a)
        3'd0: begin m_en = d[0]; m_def = d[7:4]; m_comp = d[19:8]; end
        3'd1: if (d[0]) n_ovf = 0;
        3'd2: n_fast = d[23:0];
        3'd3: begin n_per = d; n_rem = d; end
        3'd4: begin n_cnt = {m_cnt[63:32], d}; carry = 0; end
        3'd5: begin n_cnt = {d, m_cnt[31:0]}; carry = 0; end
        default: ;
      endcase
    end
    if (carry) n_ovf = 1;
    m_cnt = n_cnt; m_ovf = n_ovf; m_fast = n_fast; m_rem = n_rem;
    m_per = n_per; m_hi = n_hi;
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic r, input logic [2:0] a,
                     input logic [31:0] d, input logic wr, input string tag);
    @(negedge clk);
    we = w; re = r; addr = a; wdata = d; wrap = wr;
    #1;
    check({tag, " time_o"}, tval, m_cnt);
    if (r) check(tag, {32'd0, rdata}, {32'd0, model_read(a)});
    model_step(w, r, a, d, wr);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 3'd0, 32'd0, 0, tag);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d, input string tag);
    cyc(1, 0, a, d, 0, tag);
  endtask

  task automatic rd_reg(input logic [2:0] a, input string tag);
    cyc(0, 1, a, 32'd0, 0, tag);
  endtask

  function automatic logic [31:0] ctrl(input logic en, input logic [3:0] di, input logic [11:0] ci);
    return {12'd0, ci, di, 3'd0, en};
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) rd_reg(3'(a), "R1 reset");
    // R2 disabled: holds
    idle(5, "R2 hold");
    rd_reg(3'd4, "R2 hold");
    cyc(0, 0, 3'd0, 0, 1, "R2 wrap ignored");
    // R3 default step
    wr_reg(3'd0, ctrl(1, 4'd7, 12'd9), "R3 enable");
    idle(10, "R3 run");
    rd_reg(3'd4, "R3 count");
    // R4 burst
    wr_reg(3'd2, 32'd4, "R4 load");
    idle(2, "R4 run");
    rd_reg(3'd2, "R4 remaining");
    idle(4, "R4 run");
    rd_reg(3'd2, "R4 drained");
    rd_reg(3'd4, "R4 count");
    // R5 periodic
    wr_reg(3'd3, 32'd3, "R5 period");
    idle(10, "R5 run");
    rd_reg(3'd4, "R5 count");
    wr_reg(3'd3, 32'd0, "R5 off");
    idle(5, "R5 off run");
    rd_reg(3'd4, "R5 off count");
    // R6 burst and period together
    wr_reg(3'd3, 32'd2, "R6 period");
    wr_reg(3'd2, 32'd3, "R6 burst");
    idle(6, "R6 run");
    rd_reg(3'd4, "R6 count");
    wr_reg(3'd3, 32'd0, "R6 off");
    // R8 time writes
    wr_reg(3'd4, 32'h0000_1234, "R8 lo");
    rd_reg(3'd4, "R8 lo read");
    wr_reg(3'd5, 32'h0000_abcd, "R8 hi");
    rd_reg(3'd4, "R8 lo after hi");
    rd_reg(3'd5, "R8 hi latched");
    // R7 coherent capture across a carry into the high word
    wr_reg(3'd4, 32'hffff_fff0, "R7 setup");
    rd_reg(3'd4, "R7 lo");
    idle(4, "R7 run");
    rd_reg(3'd5, "R7 hi stale");
    rd_reg(3'd4, "R7 lo again");
    rd_reg(3'd5, "R7 hi fresh");
    // R9 wrap
    cyc(0, 0, 3'd0, 0, 1, "R9 wrap");
    rd_reg(3'd4, "R9 zeroed");
    cyc(1, 0, 3'd4, 32'h55, 1, "R9 write beats wrap");
    rd_reg(3'd4, "R9 write kept");
    // R10 overflow, carry and clear in the same cycle
    wr_reg(3'd0, ctrl(1, 4'd15, 12'd15), "R10 cfg");
    wr_reg(3'd5, 32'hffff_ffff, "R10 hi");
    wr_reg(3'd4, 32'hffff_fff0, "R10 lo");
    idle(1, "R10 run");
    cyc(1, 0, 3'd1, 32'd1, 0, "R10 clear vs set");
    rd_reg(3'd1, "R10 set wins");
    wr_reg(3'd1, 32'd1, "R10 clear");
    rd_reg(3'd1, "R10 cleared");
    // R11 unused addresses
    wr_reg(3'd6, 32'hffff_ffff, "R11 write ignored");
    rd_reg(3'd6, "R11 read zero");
    rd_reg(3'd0, "R11 ctrl unchanged");
    rd_reg(3'd1, "R11 stat unchanged");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] a; logic [31:0] d; logic w, r, wr;
      a  = 3'($urandom % 8);
      w  = ($urandom % 5) == 0;
      r  = ($urandom % 2) == 0;
      wr = ($urandom % 20) == 0;
      d  = $urandom;
      if (a == 3'd0) d[0] = ($urandom % 8) != 0;
      if (a == 3'd2) d = d & 32'h1f;
      if (a == 3'd3) d = d & 32'h7;
      cyc(w, r, a, d, wr, "R11 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule